// File: doc/BRIEF.md
# Oversampling I2C Target with Configurable Rate

This block is the target (slave) side of an I2C link. A single configuration register enables it, picks one of two SCL/SDA pin pairs, turns on the Stop interrupt and selects one of three sampling rates. Both bus lines are passed through a synchronizer and then sampled once per prescaler tick. Start and Stop conditions and SCL edges are found by comparing each sample with the one before.

After a Start, the block shifts in an address byte. If the 7-bit address matches its own address register, it pulls SDA low for the ninth clock, records the direction bit and raises a one-cycle interrupt. In the write direction it then accepts data bytes MSB first. It acknowledges each byte and keeps the last one for software. On an address mismatch it stays off the bus until the next Start.

Software sees a small register file through a synchronous write port and a read port with one cycle of latency. Status bits are cleared by writing one. The Stop interrupt fires only when the Stop status bit goes from clear to set.

Top module: `i2c_slave_ctl`

## Requirements
- R1: Register 0 (configuration) resets to 0x00 and holds enable at bit 0, rate code at bits 3:2, Stop interrupt enable at bit 4 and pin-pair select at bit 6. Bits 7, 5 and 1 read as 0. Register reads return data one clock after the address is presented.
- R2: While enable reads 1, a write to register 0 leaves the pin-pair select unchanged. A write made while enable is 0 sets the pin-pair select, even in the same write that sets enable. Select 0 uses pair 0 (scl0_in/sda0_in/sda0_pull) and select 1 uses pair 1.
- R3: The sample tick period is 15 system clocks for rate code 00, 4 for code 01 and 30 for code 10. The reserved code 11 acts as 00. Transfers complete at every code.
- R4: A Start is SDA falling while SCL is high. A Stop is SDA rising while SCL is high. A Stop sets status bit 2.
- R5: If the first byte after a Start carries the 7-bit address held in register 2 (bits 6:0) in its upper seven bits, then the block does all of the following. It drives the selected SDA low through the ninth clock. It sets status bit 1. It copies the byte's bit 0 (1 = read) into status bit 3. It pulses irq.
- R6: On an address mismatch, the block does not acknowledge, raises no interrupt and does not accept data bytes until the next Start. A repeated Start with the matching address is then served.
- R7: In the write direction, each data byte is shifted in MSB first, acknowledged and stored in register 3, and it sets status bit 0. In the read direction, data bytes are not acknowledged.
- R8: Writing 1 to bits 2:0 of register 1 clears the corresponding status bit. Writing 0 leaves it unchanged.
- R9: When Stop interrupt enable is 1, irq pulses on a Stop only if status bit 2 was clear (or is being cleared in the same cycle). A Stop that finds bit 2 already set raises no interrupt.
- R10: When a Stop is detected in the same cycle as a write that clears status bit 2, the bit ends up set and the Stop interrupt still fires.
- R11: While enable is 0, all status bits and register 3 read 0, SDA is never pulled and the bus is ignored. Enable passes through a two-flop synchronizer before it takes effect.
- R12: If the block is enabled while the selected SCL is high and SDA is low, this counts as a Start. An address byte clocked afterwards without a real Start is still matched and acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 config, 1 status, 2 own address, 3 received byte |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| irq | output | 1 | One-cycle interrupt pulse |
| scl0_in | input | 1 | SCL level, pin pair 0 |
| sda0_in | input | 1 | SDA level, pin pair 0 |
| sda0_pull | output | 1 | Pull SDA low on pair 0 |
| scl1_in | input | 1 | SCL level, pin pair 1 |
| sda1_in | input | 1 | SDA level, pin pair 1 |
| sda1_pull | output | 1 | Pull SDA low on pair 1 |

## Verification
Two events can land on the same clock edge: the bus side setting the Stop status bit, and a software write-one-to-clear of that same bit. The bench forces this overlap by writing the clear to register 1 on every clock while a Stop is being driven. It stops writing on the first clock in which irq is seen. The check requires that irq pulsed and that status bit 2 still reads 1, because the set must win over the clear. Random transfers at all rate codes also check that address-match and Stop interrupts add up correctly when Stop status is randomly left set or cleared.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_ADDR = 2'd1,
    BUS_DATA = 2'd2,
    BUS_SKIP = 2'd3
  } bus_state_e;

  localparam logic [1:0] REG_CFG  = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_OWN  = 2'd2;
  localparam logic [1:0] REG_RX   = 2'd3;
endpackage

// File: rtl/i2cs_rate_tick.sv
module i2cs_rate_tick #(
  parameter int DIV_STD  = 15,
  parameter int DIV_FAST = 4,
  parameter int DIV_SLOW = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int MAXD = (DIV_SLOW > DIV_STD) ? ((DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST)
                                             : ((DIV_STD > DIV_FAST) ? DIV_STD : DIV_FAST);
  localparam int CW = $clog2(MAXD + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] reload;

  always_comb begin
    case (rate)
      2'b01:   reload = CW'(DIV_FAST - 1);
      2'b10:   reload = CW'(DIV_SLOW - 1);
      default: reload = CW'(DIV_STD - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= reload;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cs_line_sampler.sv
module i2cs_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic psel,
  input  logic scl0,
  input  logic sda0,
  input  logic scl1,
  input  logic sda1,
  input  logic tick,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall,
  output logic sda_bit
);
  localparam int NL = 2;  // index 1 = SCL, index 0 = SDA

  logic [NL-1:0]                  raw;
  logic [NL-1:0][SYNC_STAGES-1:0] sq;
  logic                           s_scl, s_sda, p_scl, p_sda;

  assign raw   = psel ? {scl1, sda1} : {scl0, sda0};
  assign s_scl = sq[1][SYNC_STAGES-1];
  assign s_sda = sq[0][SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NL; i++) begin
      if (rst) sq[i] <= '1;
      else     sq[i] <= {sq[i][SYNC_STAGES-2:0], raw[i]};
    end
  end

  // Previous sample starts at idle-high so a low SDA under a high SCL
  // at enable time reads as a Start.
  always_ff @(posedge clk) begin
    if (rst) begin
      p_scl    <= 1'b1;
      p_sda    <= 1'b1;
      ev_start <= 1'b0;
      ev_stop  <= 1'b0;
      ev_rise  <= 1'b0;
      ev_fall  <= 1'b0;
      sda_bit  <= 1'b1;
    end else begin
      ev_start <= 1'b0;
      ev_stop  <= 1'b0;
      ev_rise  <= 1'b0;
      ev_fall  <= 1'b0;
      if (tick) begin
        p_scl    <= s_scl;
        p_sda    <= s_sda;
        sda_bit  <= s_sda;
        ev_start <= p_scl & s_scl & p_sda & ~s_sda;
        ev_stop  <= p_scl & s_scl & ~p_sda & s_sda;
        ev_rise  <= ~p_scl & s_scl;
        ev_fall  <= p_scl & ~s_scl;
      end
    end
  end
endmodule

// File: rtl/i2cs_bus_fsm.sv
module i2cs_bus_fsm
  import i2cs_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_rise,
  input  logic          ev_fall,
  input  logic          sda_bit,
  input  logic [AW-1:0] own_addr,
  output logic          sda_oe,
  output logic          hit_p,
  output logic          byte_p,
  output logic          stop_p,
  output logic          rd_dir,
  output logic [AW:0]   rx_byte,
  output bus_state_e    state
);
  localparam int BW = AW + 1;
  localparam int CW = $clog2(BW + 1);
  localparam logic [CW-1:0] FULL = CW'(BW);

  logic [BW-1:0] shreg;
  logic [CW-1:0] cnt;
  logic          ack_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= BUS_IDLE;
      shreg   <= '0;
      cnt     <= '0;
      ack_ph  <= 1'b0;
      sda_oe  <= 1'b0;
      hit_p   <= 1'b0;
      byte_p  <= 1'b0;
      stop_p  <= 1'b0;
      rd_dir  <= 1'b0;
      rx_byte <= '0;
    end else begin
      hit_p  <= 1'b0;
      byte_p <= 1'b0;
      stop_p <= 1'b0;
      if (ev_stop) begin
        state  <= BUS_IDLE;
        sda_oe <= 1'b0;
        ack_ph <= 1'b0;
        stop_p <= 1'b1;
      end else if (ev_start) begin
        state  <= BUS_ADDR;
        cnt    <= '0;
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
      end else if (state == BUS_ADDR || state == BUS_DATA) begin
        if (ev_rise && !ack_ph && cnt != FULL) begin
          shreg <= {shreg[BW-2:0], sda_bit};
          cnt   <= cnt + 1'b1;
        end
        if (ev_fall) begin
          if (ack_ph) begin
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
            cnt    <= '0;
            if (state == BUS_ADDR) state <= rd_dir ? BUS_SKIP : BUS_DATA;
          end else if (cnt == FULL) begin
            if (state == BUS_ADDR) begin
              if (shreg[BW-1:1] == own_addr) begin
                sda_oe <= 1'b1;
                ack_ph <= 1'b1;
                hit_p  <= 1'b1;
                rd_dir <= shreg[0];
              end else begin
                state <= BUS_SKIP;
              end
            end else begin
              sda_oe  <= 1'b1;
              ack_ph  <= 1'b1;
              byte_p  <= 1'b1;
              rx_byte <= shreg;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_slave_ctl.sv
module i2c_slave_ctl
  import i2cs_pkg::*;
#(
  parameter int DIV_STD     = 15,
  parameter int DIV_FAST    = 4,
  parameter int DIV_SLOW    = 30,
  parameter int SYNC_STAGES = 2,
  parameter int EN_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl0_in,
  input  logic       sda0_in,
  output logic       sda0_pull,
  input  logic       scl1_in,
  input  logic       sda1_in,
  output logic       sda1_pull
);
  localparam int AW = 7;

  logic                 cfg_en, psel, sie;
  logic [1:0]           rate;
  logic [AW-1:0]        own;
  logic [EN_STAGES-1:0] en_pipe;
  logic                 en_s, core_rst;
  logic                 tick;
  logic                 ev_start, ev_stop, ev_rise, ev_fall, sda_bit;
  logic                 sda_oe, hit_p, byte_p, stop_p, rd_dir;
  logic [AW:0]          rx_byte;
  bus_state_e           fsm_state;
  logic                 st_byte, st_match, st_stop;
  logic [2:0]           clr;
  logic [3:0]           status;
  logic                 unused_wbits;

  assign unused_wbits = ^{reg_wdata[7], reg_wdata[5], reg_wdata[1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en <= 1'b0;
      psel   <= 1'b0;
      sie    <= 1'b0;
      rate   <= 2'b00;
      own    <= '0;
    end else if (reg_we) begin
      if (reg_addr == REG_CFG) begin
        cfg_en <= reg_wdata[0];
        rate   <= reg_wdata[3:2];
        sie    <= reg_wdata[4];
        if (!cfg_en) psel <= reg_wdata[6];
      end
      if (reg_addr == REG_OWN) own <= reg_wdata[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) en_pipe <= '0;
    else     en_pipe <= {en_pipe[EN_STAGES-2:0], cfg_en};
  end
  assign en_s     = en_pipe[EN_STAGES-1];
  assign core_rst = rst | ~en_s;

  i2cs_rate_tick #(.DIV_STD(DIV_STD), .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_tick (
    .clk(clk), .rst(core_rst), .rate(rate), .tick(tick)
  );

  i2cs_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst(core_rst), .psel(psel),
    .scl0(scl0_in), .sda0(sda0_in), .scl1(scl1_in), .sda1(sda1_in),
    .tick(tick), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .sda_bit(sda_bit)
  );

  i2cs_bus_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst(core_rst),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .sda_bit(sda_bit), .own_addr(own),
    .sda_oe(sda_oe), .hit_p(hit_p), .byte_p(byte_p), .stop_p(stop_p),
    .rd_dir(rd_dir), .rx_byte(rx_byte), .state(fsm_state)
  );

  assign clr = (reg_we && reg_addr == REG_STAT) ? reg_wdata[2:0] : 3'b000;

  always_ff @(posedge clk) begin
    if (core_rst) begin
      st_byte  <= 1'b0;
      st_match <= 1'b0;
      st_stop  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      st_byte  <= (st_byte  & ~clr[0]) | byte_p;
      st_match <= (st_match & ~clr[1]) | hit_p;
      st_stop  <= (st_stop  & ~clr[2]) | stop_p;
      irq      <= hit_p | (sie & stop_p & ~(st_stop & ~clr[2]));
    end
  end

  assign status = {rd_dir, st_stop, st_match, st_byte};

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        REG_CFG:  reg_rdata <= {1'b0, psel, 1'b0, sie, rate, 1'b0, cfg_en};
        REG_STAT: reg_rdata <= {4'b0000, status};
        REG_OWN:  reg_rdata <= {1'b0, own};
        default:  reg_rdata <= rx_byte;
      endcase
    end
  end

  assign sda0_pull = sda_oe & ~psel;
  assign sda1_pull = sda_oe & psel;
endmodule

// File: rtl/i2c_slave_ctl_chk.sv
module i2c_slave_ctl_chk
  import i2cs_pkg::*;
#(
  parameter int DIV_STD  = 15,
  parameter int DIV_FAST = 4,
  parameter int DIV_SLOW = 30
) (
  input logic       clk,
  input logic       rst,
  input logic       cfg_en,
  input logic       psel,
  input logic       en_s,
  input logic       tick,
  input logic [1:0] rate,
  input logic [3:0] status,
  input logic       sda_oe,
  input logic       hit_p,
  input logic       byte_p,
  input logic       stop_p,
  input logic       sie,
  input logic       irq,
  input bus_state_e fsm_state
);
  function automatic int div_of(input logic [1:0] r);
    case (r)
      2'b01:   return DIV_FAST;
      2'b10:   return DIV_SLOW;
      default: return DIV_STD;
    endcase
  endfunction

  int         gap, exp_gap;
  logic       seen;
  logic [1:0] rate_d;

  always_ff @(posedge clk) begin
    rate_d <= rate;
    if (rst || !en_s) begin
      gap     <= 0;
      exp_gap <= 0;
      seen    <= 1'b0;
    end else if (tick) begin
      gap     <= 1;
      exp_gap <= div_of(rate_d);
      seen    <= 1'b1;
    end else begin
      gap <= gap + 1;
    end
  end

  a_r2_psel_locked: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && $past(cfg_en)) |-> psel == $past(psel));

  a_r3_tick_period: assert property (@(posedge clk) disable iff (rst)
    (tick && seen && en_s) |-> gap == exp_gap);

  a_r5_ack_has_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> (hit_p || byte_p));

  a_r6_skip_releases: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == BUS_SKIP) |-> !sda_oe);

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(hit_p) || ($past(stop_p) && $past(sie))));

  a_r11_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !en_s |=> (status == 4'b0000 && !sda_oe));
endmodule

bind i2c_slave_ctl i2c_slave_ctl_chk #(
  .DIV_STD(DIV_STD), .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)
) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .psel(psel), .en_s(en_s),
  .tick(tick), .rate(rate), .status(status), .sda_oe(sda_oe),
  .hit_p(hit_p), .byte_p(byte_p), .stop_p(stop_p), .sie(sie),
  .irq(irq), .fsm_state(fsm_state)
);

// File: tb/sim_i2c_slave_ctl.sv
module sim_i2c_slave_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq;
  logic       sda0_pull, sda1_pull;
  logic [1:0] scl_m = 2'b11;
  logic [1:0] sda_m = 2'b11;
  wire        sda0_ln = sda_m[0] & ~sda0_pull;
  wire        sda1_ln = sda_m[1] & ~sda1_pull;

  int n_chk = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  int pp = 0;
  int P = 20;
  bit done = 0;

  localparam logic [6:0] OWN = 7'h3A;

  always #2 clk = ~clk;

  i2c_slave_ctl u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl0_in(scl_m[0]), .sda0_in(sda0_ln), .sda0_pull(sda0_pull),
    .scl1_in(scl_m[1]), .sda1_in(sda1_ln), .sda1_pull(sda1_pull)
  );

  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  function automatic int div_of(input logic [1:0] r);
    case (r)
      2'b01:   return 4;
      2'b10:   return 30;
      default: return 15;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  function automatic bit line_sda();
    return (pp == 0) ? sda0_ln : sda1_ln;
  endfunction

  task automatic m_start();
    sda_m[pp] = 1'b1; bw(P);
    scl_m[pp] = 1'b1; bw(P);
    sda_m[pp] = 1'b0; bw(P);
    scl_m[pp] = 1'b0; bw(P);
  endtask

  task automatic m_stop();
    sda_m[pp] = 1'b0; bw(P);
    scl_m[pp] = 1'b1; bw(P);
    sda_m[pp] = 1'b1; bw(P);
  endtask

  task automatic m_bit(input bit b);
    sda_m[pp] = b;    bw(P);
    scl_m[pp] = 1'b1; bw(P);
    scl_m[pp] = 1'b0; bw(P);
  endtask

  task automatic m_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) m_bit(b[i]);
    sda_m[pp] = 1'b1; bw(P);
    scl_m[pp] = 1'b1; bw(P / 2);
    ack = ~line_sda();
    bw(P - P / 2);
    scl_m[pp] = 1'b0; bw(P);
  endtask

  // status model
  bit m_byte_s, m_match, m_stop_s, m_dir;
  logic [7:0] m_rx;

  function automatic logic [7:0] m_status();
    return {4'b0000, m_dir, m_stop_s, m_match, m_byte_s};
  endfunction

  task automatic model_off();
    m_byte_s = 0; m_match = 0; m_stop_s = 0; m_dir = 0; m_rx = 8'h00;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    bit a;
    int i0;
    void'($urandom(32'h5EED_1234));
    model_off();
    bw(5);
    rst = 1'b0;
    bw(2);

    // R1 reset values
    rd(2'd0, v); chk(v == 8'h00, "R1 cfg reset", v, 8'h00);
    rd(2'd1, v); chk(v == 8'h00, "R1 status reset", v, 8'h00);
    rd(2'd3, v); chk(v == 8'h00, "R1 rx reset", v, 8'h00);
    chk(irq == 1'b0, "R1 irq reset", irq, 0);

    // R1/R2 field layout, select written with enable
    wr(2'd0, 8'hFF);
    rd(2'd0, v); chk(v == 8'h5D, "R1 cfg fields", v, 8'h5D);
    wr(2'd0, 8'h1D);
    rd(2'd0, v); chk(v == 8'h5D, "R2 select locked while enabled", v, 8'h5D);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk(v == 8'h40, "R2 select locked in disabling write", v, 8'h40);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk(v == 8'h00, "R2 select free when disabled", v, 8'h00);

    wr(2'd2, {1'b0, OWN});
    rd(2'd2, v); chk(v == {1'b0, OWN}, "R5 own address", v, {1'b0, OWN});

    // R2/R5/R7 transfer on pin pair 1, rate 01
    wr(2'd0, 8'h45);
    bw(20);
    pp = 1; P = 5 * div_of(2'b01);
    i0 = irq_cnt;
    m_start();
    m_byte({OWN, 1'b0}, a); chk(a == 1'b1, "R5 ack on pair 1", a, 1);
    m_byte(8'hA5, a);       chk(a == 1'b1, "R7 data ack", a, 1);
    m_stop();
    bw(P);
    chk(irq_cnt - i0 == 1, "R5 address irq", irq_cnt - i0, 1);
    rd(2'd3, v); chk(v == 8'hA5, "R7 rx byte", v, 8'hA5);
    rd(2'd1, v); chk(v == 8'h07, "R4 status after stop", v, 8'h07);

    // R11 disable wipes and ignores
    wr(2'd0, 8'h00);
    bw(4);
    model_off();
    rd(2'd1, v); chk(v == 8'h00, "R11 status cleared", v, 8'h00);
    rd(2'd3, v); chk(v == 8'h00, "R11 rx cleared", v, 8'h00);
    pp = 0; P = 20;
    i0 = irq_cnt;
    m_start();
    m_byte({OWN, 1'b0}, a); chk(a == 1'b0, "R11 no ack when off", a, 0);
    m_stop();
    rd(2'd1, v); chk(v == 8'h00, "R11 status stays 0", v, 8'h00);
    chk(irq_cnt == i0, "R11 no irq when off", irq_cnt - i0, 0);

    // R6 mismatch ignored then repeated start served
    wr(2'd0, 8'h05);
    bw(20);
    i0 = irq_cnt;
    m_start();
    m_byte({OWN ^ 7'h01, 1'b0}, a); chk(a == 1'b0, "R6 mismatch no ack", a, 0);
    m_byte({OWN, 1'b0}, a);         chk(a == 1'b0, "R6 byte ignored", a, 0);
    rd(2'd1, v); chk(v == 8'h00, "R6 no status", v, 8'h00);
    m_start();
    m_byte({OWN, 1'b1}, a); chk(a == 1'b1, "R6 repeated start match", a, 1);
    m_byte(8'h3C, a);       chk(a == 1'b0, "R7 read dir no data ack", a, 0);
    m_stop();
    bw(P);
    chk(irq_cnt - i0 == 1, "R6 single irq", irq_cnt - i0, 1);
    rd(2'd1, v); chk(v == 8'h0E, "R5 dir bit read", v, 8'h0E);
    m_match = 1; m_stop_s = 1; m_dir = 1;

    // random transfers at all rate codes
    for (int it = 0; it < 6; it++) begin
      logic [1:0] r;
      bit sie, matched, rw, exp_ack;
      int nb, exp_irq;
      logic [6:0] ad;
      logic [7:0] d;
      logic [2:0] mask;
      r = 2'($urandom % 4);
      sie = 1'($urandom % 2);
      wr(2'd0, {3'b000, sie, r, 2'b01});
      P = 5 * div_of(r);
      matched = ($urandom % 3) != 0;
      rw = ($urandom % 4) == 0;
      nb = 1 + ($urandom % 2);
      ad = 7'($urandom % 128);
      if (matched) ad = OWN; else if (ad == OWN) ad = ad ^ 7'h01;
      exp_irq = (matched ? 1 : 0) + ((sie && !m_stop_s) ? 1 : 0);
      i0 = irq_cnt;
      m_start();
      m_byte({ad, rw}, a);
      chk(a == matched, matched ? "R5 random ack" : "R6 random nack", a, matched);
      for (int b = 0; b < nb; b++) begin
        d = 8'($urandom);
        exp_ack = matched && !rw;
        m_byte(d, a);
        chk(a == exp_ack, "R7 random data ack", a, exp_ack);
        if (exp_ack) m_rx = d;
      end
      m_stop();
      bw(P);
      if (matched) begin
        m_match = 1; m_dir = rw;
        if (!rw) m_byte_s = 1;
      end
      m_stop_s = 1;
      chk(irq_cnt - i0 == exp_irq, "R9 irq count", irq_cnt - i0, exp_irq);
      rd(2'd1, v); chk(v == m_status(), "R3 status at rate", v, m_status());
      rd(2'd3, v); chk(v == m_rx, "R7 rx random", v, m_rx);
      mask = 3'($urandom % 8);
      wr(2'd1, {5'b00000, mask});
      if (mask[0]) m_byte_s = 0;
      if (mask[1]) m_match = 0;
      if (mask[2]) m_stop_s = 0;
      rd(2'd1, v); chk(v == m_status(), "R8 write-one clear", v, m_status());
    end

    // R9 second stop with bit set: no irq
    wr(2'd0, 8'h15);
    P = 20;
    wr(2'd1, 8'h07);
    m_byte_s = 0; m_match = 0; m_stop_s = 0;
    m_start(); m_byte({OWN ^ 7'h02, 1'b0}, a); m_stop(); bw(P);
    i0 = irq_cnt;
    m_start(); m_byte({OWN ^ 7'h02, 1'b0}, a); m_stop(); bw(P);
    chk(irq_cnt == i0, "R9 no irq while stop bit set", irq_cnt - i0, 0);

    // R10 stop coinciding with clear
    begin
      bit got;
      got = 0;
      i0 = irq_cnt;
      m_start(); m_byte({OWN ^ 7'h02, 1'b0}, a);
      fork
        m_stop();
        begin
          for (int k = 0; k < 2000 && !got; k++) begin
            @(negedge clk);
            if (irq) begin got = 1; reg_we = 1'b0; end
            else begin reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h04; end
          end
          reg_we = 1'b0;
        end
      join
      chk(got, "R10 irq with same-cycle clear", got, 1);
      rd(2'd1, v); chk(v[2] == 1'b1, "R10 set wins", v[2], 1);
    end

    // R12 enable with SCL high, SDA low
    wr(2'd0, 8'h00);
    bw(4);
    pp = 0; P = 20;
    scl_m[0] = 1'b1; sda_m[0] = 1'b0;
    bw(4);
    wr(2'd0, 8'h05);
    bw(40);
    scl_m[0] = 1'b0; bw(P);
    m_byte({OWN, 1'b0}, a); chk(a == 1'b1, "R12 false start address ack", a, 1);
    m_stop();
    rd(2'd1, v); chk(v[1] == 1'b1, "R12 match bit", v[1], 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule